// File: doc/BRIEF.md
# Accumulation Cycle Sequencer

This block paces the sampling front end of a metering datapath. A slow tick enable, one pulse per period of a 32768 Hz reference, drives a frame timer. Each frame, called a multiplexer cycle, lasts a fixed number of ticks. Within a frame the block issues four one-clock sample strobes at fixed tick positions, in the order current A, voltage A, current B, voltage B. At the close of every frame it raises a frame interrupt.

Frames are grouped into accumulation cycles. The length of an accumulation cycle in frames is the product of a pre-sample count, selected by a 2-bit code, and a 6-bit sum count. Both values are read from one 8-bit configuration input. When the final frame of an accumulation cycle closes, a transfer interrupt tells the host that accumulated results can be collected. The configuration is sampled while reset is held and again at each accumulation boundary. A write in the middle of a cycle therefore only affects the cycle that follows.

Top module: `acs_sequencer`

## Requirements
- R1: While rst_n is low on a clock edge, every output is low after that edge, whatever tick_i does. After release, the first tick is tick 0 of a fresh frame and the first frame of a fresh accumulation cycle.
- R2: A frame is FRAME_TICKS ticks long (default 13). mux_irq_o is a one-clock pulse in the clock after the last tick of each frame.
- R3: smp_stb_o bit 0 (current A), bit 1 (voltage A), bit 2 (current B) and bit 3 (voltage B) each pulse for one clock, in the clock after frame ticks 0, 1, 2 and 3 respectively (default placement). At most one bit is high at a time.
- R4: A clock with tick_i low does not advance the frame and produces no strobe or interrupt.
- R5: The pre-sample code cfg_i[7:6] selects a pre-sample count: 0 gives 42, 1 gives 50, 2 gives 84 and 3 gives 100.
- R6: cfg_i[5:0] is the sum count, where 0 stands for 64. An accumulation cycle spans pre-sample count × sum count frames, and xfer_irq_o pulses for one clock at its end. For example, codes 0/50 and 3/21 both give 2100 frames.
- R7: xfer_irq_o is high only in the same clock as a mux_irq_o pulse.
- R8: A change on cfg_i during an accumulation cycle has no effect until the next cycle begins. cfg_i is sampled in the clock where the current cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock enable per 32768 Hz period |
| cfg_i | input | 8 | [7:6] pre-sample code, [5:0] sum count |
| smp_stb_o | output | 4 | Sample strobes: IA, VA, IB, VB in bits 0..3 |
| mux_irq_o | output | 1 | End-of-frame interrupt pulse |
| xfer_irq_o | output | 1 | End-of-accumulation interrupt pulse |

## Verification
The assertions treat tick_i as an arbitrary enable that may be high on any number of consecutive clocks. They also assume cfg_i is allowed to move at any time outside reset. The stimulus stays within both assumptions: it holds tick_i high continuously for whole accumulation cycles, sends a sparse pattern of isolated ticks, and rewrites cfg_i partway through a cycle. Because cfg_i is loaded on every reset edge, the configuration-hold property only applies from the second clock after reset release. For the same reason, the bench holds cfg_i steady for the whole time reset is asserted.

// File: rtl/acs_pkg.sv
// Package: shared configuration layout and pre-sample decoding for the
// accumulation cycle sequencer. Assumes the 8-bit configuration format
// with the code in the two top bits and the sum count below it.
package acs_pkg;

    localparam int CHAN_N    = 4;
    localparam int CODE_W    = 2;
    localparam int SUM_W     = 6;
    localparam int PRE_CNT_W = 7;

    typedef enum logic [1:0] {
        CH_IA = 2'd0,
        CH_VA = 2'd1,
        CH_IB = 2'd2,
        CH_VB = 2'd3
    } chan_e;

    typedef struct packed {
        logic [CODE_W-1:0] pre_code;
        logic [SUM_W-1:0]  sum_cnt;
    } acc_cfg_t;

    // Decode the 2-bit pre-sample code into a frame count.
    function automatic logic [PRE_CNT_W-1:0] pre_count(input logic [CODE_W-1:0] code);
        case (code)
            2'd0:    pre_count = 7'd42;
            2'd1:    pre_count = 7'd50;
            2'd2:    pre_count = 7'd84;
            default: pre_count = 7'd100;
        endcase
    endfunction

endpackage

// File: rtl/acs_frame_timer.sv
// Frame timer: counts tick enables across one multiplexer cycle of
// FRAME_TICKS ticks. It registers a strobe for each sample slot and a
// frame interrupt. It also reports the closing tick combinationally, so
// the accumulation counter can act in the same clock.
// Assumes SLOT_FIRST + (CHAN_N-1)*SLOT_GAP < FRAME_TICKS.
module acs_frame_timer
    import acs_pkg::*;
#(
    parameter int FRAME_TICKS = 13,
    parameter int SLOT_FIRST  = 0,
    parameter int SLOT_GAP    = 1,
    localparam int PH_W = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic              frame_end_o,
    output logic [CHAN_N-1:0] smp_stb_o,
    output logic              mux_irq_o
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_TICKS - 1);

    logic [PH_W-1:0]   phase_q;
    logic [CHAN_N-1:0] slot_hit;
    logic [CHAN_N-1:0] stb_q;
    logic              irq_q;

    // Closing tick of the current frame.
    assign frame_end_o = tick_i && (phase_q == PH_LAST);

    // One slot decoder per channel, placed at its fixed tick offset.
    for (genvar k = 0; k < CHAN_N; k++) begin : g_slot
        localparam logic [PH_W-1:0] SLOT_PH = PH_W'(SLOT_FIRST + k * SLOT_GAP);
        assign slot_hit[k] = tick_i && (phase_q == SLOT_PH);
    end

    // Advance the tick position within the frame, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
        end
    end

    // Register the sample strobes and the frame interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= '0;
            irq_q <= 1'b0;
        end else begin
            stb_q <= slot_hit;
            irq_q <= frame_end_o;
        end
    end

    assign smp_stb_o = stb_q;
    assign mux_irq_o = irq_q;

    a_r2_phase_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= PH_LAST);

    a_r2_mux_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_q));

    a_r4_idle_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(phase_q));

    a_r4_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (stb_q == '0) && !irq_q);

endmodule

// File: rtl/acs_accum_counter.sv
// Accumulation counter: counts closed frames in two levels. The inner
// level counts up to the decoded pre-sample count; the outer level counts
// up to the sum count, where 0 stands for 64. It latches the configuration
// at reset and at each accumulation boundary, and raises the transfer
// interrupt. Assumes frame_end_i is high for one clock per frame.
module acs_accum_counter
    import acs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg_i,
    input  logic       frame_end_i,
    output logic       xfer_irq_o
);

    acc_cfg_t             act_cfg_q;
    logic [PRE_CNT_W-1:0] pre_q;
    logic [SUM_W-1:0]     sum_q;
    logic [PRE_CNT_W-1:0] pre_last_val;
    logic [SUM_W-1:0]     sum_last_val;
    logic                 pre_last;
    logic                 sum_last;
    logic                 acc_end;
    logic                 xfer_q;

    // Terminal values for both counter levels; the sum level wraps 0 to 63.
    always_comb begin
        pre_last_val = pre_count(act_cfg_q.pre_code) - PRE_CNT_W'(1);
        sum_last_val = act_cfg_q.sum_cnt - SUM_W'(1);
        pre_last     = (pre_q == pre_last_val);
        sum_last     = (sum_q == sum_last_val);
        acc_end      = frame_end_i && pre_last && sum_last;
    end

    // Load the working configuration only at reset or an accumulation boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_end) begin
            act_cfg_q <= acc_cfg_t'(cfg_i);
        end
    end

    // Two-level frame counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            sum_q <= '0;
        end else if (frame_end_i) begin
            if (pre_last) begin
                pre_q <= '0;
                sum_q <= sum_last ? '0 : sum_q + SUM_W'(1);
            end else begin
                pre_q <= pre_q + PRE_CNT_W'(1);
            end
        end
    end

    // Register the transfer interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_q <= 1'b0;
        else        xfer_q <= acc_end;
    end

    assign xfer_irq_o = xfer_q;

    a_r5_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q < pre_count(act_cfg_q.pre_code));

    a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(acc_end)) |-> $stable(act_cfg_q));

    a_r6_xfer_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_q |=> !xfer_q);

endmodule

// File: rtl/acs_sequencer.sv
// Top level of the accumulation cycle sequencer. It joins the frame timer,
// which handles tick pacing, sample strobes and the frame interrupt, to the
// accumulation counter, which handles frame grouping and the transfer
// interrupt. Assumes tick_i is synchronous to clk, one clock per tick.
module acs_sequencer
    import acs_pkg::*;
#(
    parameter int FRAME_TICKS = 13,
    parameter int SLOT_FIRST  = 0,
    parameter int SLOT_GAP    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [7:0] cfg_i,
    output logic [3:0] smp_stb_o,
    output logic       mux_irq_o,
    output logic       xfer_irq_o
);

    logic frame_end;

    acs_frame_timer #(
        .FRAME_TICKS (FRAME_TICKS),
        .SLOT_FIRST  (SLOT_FIRST),
        .SLOT_GAP    (SLOT_GAP)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .frame_end_o (frame_end),
        .smp_stb_o   (smp_stb_o),
        .mux_irq_o   (mux_irq_o)
    );

    acs_accum_counter u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg_i),
        .frame_end_i (frame_end),
        .xfer_irq_o  (xfer_irq_o)
    );

    a_r7_xfer_with_mux: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq_o |-> mux_irq_o);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (smp_stb_o == 4'd0) && !mux_irq_o && !xfer_irq_o);

endmodule

// File: tb/acs_sequencer_tb.sv
module acs_sequencer_tb_top;

    localparam int FT    = 13;
    localparam int NVEC  = 8;
    localparam int WATCH = 190000;

    // Vector table: configuration byte and expected clocks to the first transfer
    // with tick held high (13 * pre * sum).
    localparam logic [7:0] VEC_CFG [NVEC] = '{8'h01, 8'h41, 8'h82, 8'hC1,
                                              8'h02, 8'hD5, 8'h32, 8'h00};
    localparam int         VEC_LEN [NVEC] = '{546, 650, 2184, 1300,
                                              1092, 27300, 27300, 34944};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cfg = 8'h01;
    logic [3:0] stb;
    logic       mux_irq;
    logic       xfer_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    acs_sequencer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .cfg_i      (cfg),
        .smp_stb_o  (stb),
        .mux_irq_o  (mux_irq),
        .xfer_irq_o (xfer_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCH) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d", cyc, WATCH);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // R1: hold reset with ticks running; outputs must stay low.
    task automatic do_reset(input logic [7:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        tick = 1'b1;
        cfg = c;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check(stb == 4'd0 && !mux_irq && !xfer_irq, "R1 reset quiet",
              {stb, mux_irq, xfer_irq}, 0);
        rst_n = 1'b1;
    endtask

    // Continuous ticks: compare every clock against the frame and cycle model.
    // Optionally rewrite cfg at clock chg_at (R8).
    task automatic run_cont(input int len, input int xfer2, input int chg_at,
                            input logic [7:0] chg_cfg, input string tag);
        int e_stb = 0, e_mux = 0, e_x = 0;
        int f_stb = 0, f_mux = 0, f_x = 0;
        int stop = (xfer2 > 0) ? xfer2 + FT : len + FT;
        for (int n = 1; n <= stop; n++) begin
            int ph;
            logic [3:0] xs;
            @(posedge clk); @(negedge clk);
            if (n == chg_at) cfg = chg_cfg;
            ph = (n - 1) % FT;
            xs = (ph < 4) ? 4'(1 << ph) : 4'd0;
            if (stb != xs && e_stb == 0) begin e_stb = 1; f_stb = n; end
            if (mux_irq != (ph == FT - 1) && e_mux == 0) begin e_mux = 1; f_mux = n; end
            if (xfer_irq != (n == len || n == xfer2) && e_x == 0) begin e_x = 1; f_x = n; end
        end
        check(e_stb == 0, {tag, " R3 strobe order"}, f_stb, 0);
        check(e_mux == 0, {tag, " R2 frame irq"}, f_mux, 0);
        check(e_x == 0, {tag, " R6 xfer clock"}, f_x, len);
    endtask

    initial begin
        // Table walk: R5 codes, R6 sum counts (including 0 = 64), R7 coincidence.
        for (int v = 0; v < NVEC; v++) begin
            do_reset(VEC_CFG[v]);
            run_cont(VEC_LEN[v], 0, -1, 8'h00, $sformatf("vec%0d", v));
        end

        // R4: idle clocks after reset produce nothing.
        do_reset(8'h01);
        tick = 1'b0;
        begin
            int seen = 0;
            for (int n = 0; n < 30; n++) begin
                @(posedge clk); @(negedge clk);
                if (stb != 0 || mux_irq || xfer_irq) seen++;
            end
            check(seen == 0, "R4 idle quiet", seen, 0);
        end

        // R4/R2/R3: sparse ticks with two idle clocks between them.
        begin
            int err = 0;
            int muxes = 0;
            for (int t = 0; t < FT; t++) begin
                logic [3:0] xs;
                tick = 1'b1;
                @(posedge clk); @(negedge clk);
                tick = 1'b0;
                xs = (t < 4) ? 4'(1 << t) : 4'd0;
                if (stb != xs) err++;
                if (mux_irq) muxes++;
                if (mux_irq != (t == FT - 1)) err++;
                for (int g = 0; g < 2; g++) begin
                    @(posedge clk); @(negedge clk);
                    if (stb != 0 || mux_irq || xfer_irq) err++;
                end
            end
            check(err == 0, "R4 sparse ticks", err, 0);
            check(muxes == 1, "R2 one frame irq per 13 ticks", muxes, 1);
        end

        // R8: change code 0 -> code 1 mid-cycle; transfers at 546, then 546+650.
        do_reset(8'h01);
        run_cont(546, 1196, 100, 8'h41, "cfgchg R8");

        // R1: reset in mid-frame restarts the frame at tick 0.
        do_reset(8'h01);
        for (int n = 0; n < 7; n++) begin @(posedge clk); @(negedge clk); end
        do_reset(8'h01);
        run_cont(546, 0, -1, 8'h00, "midreset R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule